// File: doc/BRIEF.md
# Debug Watchpoint Qualifier and Exception Reporter

This block sits behind the address comparators of a processor's hardware watchpoints. When a load or store has raised a raw hit on one or more watchpoint slots, the block decides whether that hit is allowed to become a debug exception. It applies three kinds of filter to every slot: the security-state filter, the privilege filter (including the hypervisor-level enable) and the optional link to a context breakpoint. It also applies two global gates: the watchpoint enable bit in the debug control word and the debug-exceptions-allowed flag. If any slot survives, the block packs an exception syndrome word, a fault status word and the faulting address. If no slot survives, it signals that execution should resume.

Each decision starts with a request on a valid/ready handshake, and all request inputs are captured on the accepting clock edge. The controller has four states:
- `ST_IDLE`: the block is ready and waiting for a request.
- `ST_DECIDE`: the captured hit is evaluated.
- `ST_TAKE`: the exception report is presented.
- `ST_RESUME`: the resume indication is presented.

The transitions are:
- *accept* (`ST_IDLE` to `ST_DECIDE`), when `req_valid` is high while ready.
- *qualify* (`ST_DECIDE` to `ST_TAKE`), when at least one slot passes and the global gates are open.
- *reject* (`ST_DECIDE` to `ST_RESUME`), otherwise.
- *retire* (`ST_TAKE` or `ST_RESUME` back to `ST_IDLE`), after one cycle.

Comparing addresses and evaluating the linked breakpoint are done elsewhere. This block receives a per-breakpoint pass vector.

Top module: `dwq_watch_gate`

## Requirements
- R1: A hit is only taken when bit 15 of `dbg_ctrl` and `dbg_allowed` are both 1 at acceptance. Otherwise the request ends in a resume, whatever the slots hold.
- R2: A slot is considered only when its `slot_hit` bit is 1. Its 32-bit control word in `slot_ctrl[32*s +: 32]` is decoded with the following fields:
  - privilege mask at bits 2:1;
  - hypervisor-level enable at bit 13;
  - security filter at bits 15:14;
  - link index at bits 19:16;
  - link enable at bit 20.
- R3: Security filter value 0 passes in either state. Values 1 and 3 pass only when `secure` is 0. Value 2 passes only when `secure` is 1.
- R4: The privilege filter depends on `cur_level`:
  - at level 2 or 3 the slot needs the hypervisor-level enable set;
  - at level 1 it needs privilege mask bit 0 (control bit 1);
  - at level 0 it needs privilege mask bit 1 (control bit 2).
- R5: When link enable is 1, the slot passes only if `link_pass[link index]` is 1. A link index of `NUM_BRK` or more always fails.
- R6: The request is taken when at least one slot passes all filters. It resumes when no slot does, including when no raw hit is present.
- R7: On a take, the syndrome is built as follows:
  - bits 31:26 hold 0x35 when `target_level` equals `cur_level`, and 0x34 otherwise;
  - bit 25 is 1;
  - bits 24:7 are 0;
  - bit 6 is `is_write`;
  - bits 5:0 are 0x22.
- R8: On a take, `exc_fsr` is 0x222 when `long_desc` is 1 and 0x002 when it is 0, and `exc_addr` equals the captured `hit_addr`.
- R9: A request is accepted on a rising edge where `req_valid` and `req_ready` are both 1. The result is shown for exactly one cycle, beginning at the second rising edge after acceptance. `req_ready` stays 0 from acceptance until that result cycle ends.
- R10: Each accepted request gives exactly one of `exc_valid` or `resume_valid`. Outside a take, `exc_syndrome`, `exc_fsr` and `exc_addr` are 0. After reset the block is ready with both strobes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| slot_hit | input | NUM_SLOTS | Raw address/access hit per slot |
| slot_ctrl | input | 32*NUM_SLOTS | Control word per slot |
| cur_level | input | 2 | Current exception level |
| secure | input | 1 | Current security state is secure |
| target_level | input | 2 | Level that debug exceptions are routed to |
| dbg_ctrl | input | 32 | Debug control word, bit 15 enables watchpoints |
| dbg_allowed | input | 1 | Debug exceptions currently permitted |
| is_write | input | 1 | Access was a write |
| hit_addr | input | ADDR_W | Address that hit |
| long_desc | input | 1 | Long-descriptor translation format active |
| link_pass | input | NUM_BRK | Per-breakpoint linked-check result |
| exc_valid | output | 1 | Take-exception strobe |
| exc_syndrome | output | 32 | Syndrome word |
| exc_fsr | output | 32 | Fault status word |
| exc_addr | output | ADDR_W | Faulting address |
| resume_valid | output | 1 | Resume strobe |

## Verification
The hardest cases to reach from the ports are those where filters disagree across slots. One example is a low slot with a raw hit that fails only its link check while a higher slot passes. Another is a request held valid through the busy window, which must be accepted exactly once as the block returns to `ST_IDLE`. Directed requests build these cases from hand-encoded control words: one filter at a time, out-of-range link indices, and a continuously held request whose inputs change at the re-acceptance edge. A long run of random requests with random control words and gaps then goes through a behavioural per-clock model.

// File: rtl/dwq_pkg.sv
package dwq_pkg;

    localparam int CTRL_W   = 32;
    localparam int PAC_LO   = 1;
    localparam int HMC_BIT  = 13;
    localparam int SSC_LO   = 14;
    localparam int LBN_LO   = 16;
    localparam int LBN_W    = 4;
    localparam int WT_BIT   = 20;
    localparam int GATE_BIT = 15;
    localparam int SYN_W    = 32;

    localparam logic [5:0]       EC_LOWER  = 6'h34;
    localparam logic [5:0]       EC_SAME   = 6'h35;
    localparam logic [5:0]       ISS_LOW   = 6'h22;
    localparam logic [SYN_W-1:0] FSR_LONG  = 32'h0000_0222;
    localparam logic [SYN_W-1:0] FSR_SHORT = 32'h0000_0002;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_DECIDE,
        ST_TAKE,
        ST_RESUME
    } dwq_state_e;

endpackage

// File: rtl/dwq_slot_check.sv
module dwq_slot_check
    import dwq_pkg::*;
#(
    parameter int NUM_BRK = 16
) (
    input  logic               raw_hit,
    input  logic [CTRL_W-1:0]  ctrl,
    input  logic [1:0]         level,
    input  logic               secure,
    input  logic [NUM_BRK-1:0] link_pass,
    output logic               qualified
);

    logic [1:0]       pac;
    logic             hmc;
    logic [1:0]       ssc;
    logic [LBN_W-1:0] lbn;
    logic             wt;
    logic             sec_ok;
    logic             lvl_ok;
    logic             link_hit;
    logic             unused_ctrl;

    assign pac = ctrl[PAC_LO +: 2];
    assign hmc = ctrl[HMC_BIT];
    assign ssc = ctrl[SSC_LO +: 2];
    assign lbn = ctrl[LBN_LO +: LBN_W];
    assign wt  = ctrl[WT_BIT];
    assign unused_ctrl = ^{ctrl[CTRL_W-1:WT_BIT+1], ctrl[HMC_BIT-1:PAC_LO+2], ctrl[0]};

    always_comb begin
        unique case (ssc)
            2'd0:    sec_ok = 1'b1;
            2'd2:    sec_ok = secure;
            default: sec_ok = ~secure;
        endcase
    end

    always_comb begin
        unique case (level)
            2'd0:    lvl_ok = pac[1];
            2'd1:    lvl_ok = pac[0];
            default: lvl_ok = hmc;
        endcase
    end

    // Index into the breakpoint result vector; indices past NUM_BRK stay 0.
    always_comb begin
        link_hit = 1'b0;
        for (int b = 0; b < NUM_BRK; b++) begin
            if (int'(lbn) == b) link_hit = link_pass[b];
        end
    end

    assign qualified = raw_hit & sec_ok & lvl_ok & (~wt | link_hit);

endmodule

// File: rtl/dwq_report_pack.sv
module dwq_report_pack
    import dwq_pkg::*;
(
    input  logic             same_level,
    input  logic             is_write,
    input  logic             long_desc,
    output logic [SYN_W-1:0] syndrome,
    output logic [SYN_W-1:0] fsr
);

    logic [5:0] ec;

    assign ec       = same_level ? EC_SAME : EC_LOWER;
    assign syndrome = {ec, 1'b1, 17'd0, 1'b0, is_write, ISS_LOW};
    assign fsr      = long_desc ? FSR_LONG : FSR_SHORT;

endmodule

// File: rtl/dwq_watch_gate.sv
module dwq_watch_gate
    import dwq_pkg::*;
#(
    parameter int NUM_SLOTS = 4,
    parameter int NUM_BRK   = 16,
    parameter int ADDR_W    = 32
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        req_valid,
    output logic                        req_ready,
    input  logic [NUM_SLOTS-1:0]        slot_hit,
    input  logic [NUM_SLOTS*CTRL_W-1:0] slot_ctrl,
    input  logic [1:0]                  cur_level,
    input  logic                        secure,
    input  logic [1:0]                  target_level,
    input  logic [31:0]                 dbg_ctrl,
    input  logic                        dbg_allowed,
    input  logic                        is_write,
    input  logic [ADDR_W-1:0]           hit_addr,
    input  logic                        long_desc,
    input  logic [NUM_BRK-1:0]          link_pass,
    output logic                        exc_valid,
    output logic [SYN_W-1:0]            exc_syndrome,
    output logic [SYN_W-1:0]            exc_fsr,
    output logic [ADDR_W-1:0]           exc_addr,
    output logic                        resume_valid
);

    localparam int CTRL_BITS = NUM_SLOTS * CTRL_W;

    dwq_state_e state_q, state_d;

    logic                   accept;
    logic [NUM_SLOTS-1:0]   hit_q;
    logic [CTRL_BITS-1:0]   ctrl_q;
    logic [1:0]             lvl_q;
    logic [1:0]             tgt_q;
    logic                   sec_q;
    logic                   gate_q;
    logic                   wr_q;
    logic                   long_q;
    logic [ADDR_W-1:0]      addr_q;
    logic [NUM_BRK-1:0]     link_q;

    logic [NUM_SLOTS-1:0]   slot_ok;
    logic                   take;
    logic [SYN_W-1:0]       syn_w;
    logic [SYN_W-1:0]       fsr_w;
    logic [SYN_W-1:0]       syn_q;
    logic [SYN_W-1:0]       fsr_q;
    logic [ADDR_W-1:0]      rep_addr_q;
    logic                   unused_dbg;

    assign unused_dbg = ^{dbg_ctrl[31:GATE_BIT+1], dbg_ctrl[GATE_BIT-1:0]};
    assign accept     = req_valid && (state_q == ST_IDLE);

    // Capture every request input on the accepting edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hit_q  <= '0;
            ctrl_q <= '0;
            lvl_q  <= '0;
            tgt_q  <= '0;
            sec_q  <= 1'b0;
            gate_q <= 1'b0;
            wr_q   <= 1'b0;
            long_q <= 1'b0;
            addr_q <= '0;
            link_q <= '0;
        end else if (accept) begin
            hit_q  <= slot_hit;
            ctrl_q <= slot_ctrl;
            lvl_q  <= cur_level;
            tgt_q  <= target_level;
            sec_q  <= secure;
            gate_q <= dbg_ctrl[GATE_BIT] & dbg_allowed;
            wr_q   <= is_write;
            long_q <= long_desc;
            addr_q <= hit_addr;
            link_q <= link_pass;
        end
    end

    for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
        dwq_slot_check #(
            .NUM_BRK (NUM_BRK)
        ) u_slot (
            .raw_hit   (hit_q[s]),
            .ctrl      (ctrl_q[s*CTRL_W +: CTRL_W]),
            .level     (lvl_q),
            .secure    (sec_q),
            .link_pass (link_q),
            .qualified (slot_ok[s])
        );
    end

    assign take = gate_q & (|slot_ok);

    dwq_report_pack u_pack (
        .same_level (tgt_q == lvl_q),
        .is_write   (wr_q),
        .long_desc  (long_q),
        .syndrome   (syn_w),
        .fsr        (fsr_w)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req_valid) state_d = ST_DECIDE;
            ST_DECIDE: state_d = take ? ST_TAKE : ST_RESUME;
            ST_TAKE:   state_d = ST_IDLE;
            ST_RESUME: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            syn_q      <= '0;
            fsr_q      <= '0;
            rep_addr_q <= '0;
        end else if (state_q == ST_DECIDE) begin
            syn_q      <= syn_w;
            fsr_q      <= fsr_w;
            rep_addr_q <= addr_q;
        end
    end

    always_comb begin
        req_ready    = 1'b0;
        exc_valid    = 1'b0;
        resume_valid = 1'b0;
        exc_syndrome = '0;
        exc_fsr      = '0;
        exc_addr     = '0;
        unique case (state_q)
            ST_IDLE:   req_ready = 1'b1;
            ST_DECIDE: ;
            ST_TAKE: begin
                exc_valid    = 1'b1;
                exc_syndrome = syn_q;
                exc_fsr      = fsr_q;
                exc_addr     = rep_addr_q;
            end
            ST_RESUME: resume_valid = 1'b1;
            default:   ;
        endcase
    end

endmodule

// File: rtl/dwq_watch_gate_chk.sv
module dwq_watch_gate_chk #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              gate_bit,
    input logic              dbg_allowed,
    input logic [ADDR_W-1:0] hit_addr,
    input logic              exc_valid,
    input logic [31:0]       exc_syndrome,
    input logic [31:0]       exc_fsr,
    input logic [ADDR_W-1:0] exc_addr,
    input logic              resume_valid
);

    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid || resume_valid) |=> !(exc_valid || resume_valid));

    a_r10_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_valid && resume_valid));

    a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid || resume_valid) |-> !req_ready);

    a_r9_result_from_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid || resume_valid) |-> $past(req_valid && req_ready, 2));

    a_r1_gate_honoured: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> $past(gate_bit && dbg_allowed, 2));

    a_r8_addr_echo: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_addr == $past(hit_addr, 2)));

    a_r8_fsr_code: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_fsr == 32'h222 || exc_fsr == 32'h002));

    a_r7_syndrome_shape: assert property (@(posedge clk) disable iff (!rst_n)
        exc_valid |-> (exc_syndrome[5:0] == 6'h22 && exc_syndrome[25]
                       && exc_syndrome[31:27] == 5'b11010 && exc_syndrome[24:7] == 18'd0));

    a_r10_quiet_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        !exc_valid |-> (exc_syndrome == 32'd0 && exc_fsr == 32'd0 && exc_addr == '0));

endmodule

bind dwq_watch_gate dwq_watch_gate_chk #(
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .gate_bit     (dbg_ctrl[15]),
    .dbg_allowed  (dbg_allowed),
    .hit_addr     (hit_addr),
    .exc_valid    (exc_valid),
    .exc_syndrome (exc_syndrome),
    .exc_fsr      (exc_fsr),
    .exc_addr     (exc_addr),
    .resume_valid (resume_valid)
);

// File: tb/dwq_watch_gate_tb.sv
module dwq_watch_gate_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 4;
    localparam int NB = 12;
    localparam int AW = 32;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [NS-1:0]     slot_hit = '0;
    logic [NS*32-1:0]  slot_ctrl = '0;
    logic [1:0]        cur_level = 2'd0;
    logic              secure = 1'b0;
    logic [1:0]        target_level = 2'd1;
    logic [31:0]       dbg_ctrl = 32'h0000_8000;
    logic              dbg_allowed = 1'b1;
    logic              is_write = 1'b0;
    logic [AW-1:0]     hit_addr = '0;
    logic              long_desc = 1'b0;
    logic [NB-1:0]     link_pass = '1;
    logic              exc_valid;
    logic [31:0]       exc_syndrome;
    logic [31:0]       exc_fsr;
    logic [AW-1:0]     exc_addr;
    logic              resume_valid;

    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    string cur_tag = "R10";

    int          m_st = 0;
    bit          m_take = 0;
    logic [31:0] m_syn, m_fsr;
    logic [AW-1:0] m_addr;
    logic [31:0] last_syn, last_fsr;
    logic [AW-1:0] last_addr;

    always #(CLK_PERIOD/2) clk = ~clk;

    dwq_watch_gate #(.NUM_SLOTS(NS), .NUM_BRK(NB), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .slot_hit(slot_hit), .slot_ctrl(slot_ctrl), .cur_level(cur_level),
        .secure(secure), .target_level(target_level), .dbg_ctrl(dbg_ctrl),
        .dbg_allowed(dbg_allowed), .is_write(is_write), .hit_addr(hit_addr),
        .long_desc(long_desc), .link_pass(link_pass), .exc_valid(exc_valid),
        .exc_syndrome(exc_syndrome), .exc_fsr(exc_fsr), .exc_addr(exc_addr),
        .resume_valid(resume_valid)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic bit [31:0] mk(int pac, int hmc, int ssc, int lbn, int wt);
        return (32'(pac) << 1) | (32'(hmc) << 13) | (32'(ssc) << 14)
             | (32'(lbn) << 16) | (32'(wt) << 20);
    endfunction

    // Behavioural decision from the requirements (R1..R6).
    function automatic bit ref_take();
        if (dbg_ctrl[15] == 1'b0 || !dbg_allowed) return 0;
        for (int s = 0; s < NS; s++) begin
            bit [31:0] w;
            int pac, hmc, ssc, lbn, wt;
            bit ok;
            w   = slot_ctrl[s*32 +: 32];
            pac = int'((w >> 1) & 3);
            hmc = int'((w >> 13) & 1);
            ssc = int'((w >> 14) & 3);
            lbn = int'((w >> 16) & 15);
            wt  = int'((w >> 20) & 1);
            ok  = slot_hit[s];
            if (ssc == 2 && !secure) ok = 0;
            if ((ssc == 1 || ssc == 3) && secure) ok = 0;
            if (cur_level >= 2 && hmc == 0) ok = 0;
            if (cur_level == 1 && (pac % 2) == 0) ok = 0;
            if (cur_level == 0 && pac < 2) ok = 0;
            if (wt == 1 && (lbn >= NB || !link_pass[lbn])) ok = 0;
            if (ok) return 1;
        end
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) m_st = 0;
        else begin
            case (m_st)
                0: if (req_valid) begin
                    m_take = ref_take();
                    m_syn  = ((target_level == cur_level) ? 32'h35 : 32'h34) << 26;
                    m_syn  = m_syn | 32'h0200_0000 | (32'(is_write) << 6) | 32'h22;
                    m_fsr  = long_desc ? 32'h222 : 32'h002;
                    m_addr = hit_addr;
                    m_st   = 1;
                end
                1: m_st = 2;
                default: m_st = 0;
            endcase
        end
    end

    // Per-clock comparison against the model (R9, R10 plus current scenario tag).
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit ev;
            ev = (m_st == 2) && m_take;
            chk({cur_tag, " R9 ready"}, 64'(req_ready), 64'(m_st == 0));
            chk({cur_tag, " R10 exc"}, 64'(exc_valid), 64'(ev));
            chk({cur_tag, " R10 resume"}, 64'(resume_valid), 64'((m_st == 2) && !m_take));
            chk({cur_tag, " R7 syndrome"}, 64'(exc_syndrome), ev ? 64'(m_syn) : 64'd0);
            chk({cur_tag, " R8 fsr"}, 64'(exc_fsr), ev ? 64'(m_fsr) : 64'd0);
            chk({cur_tag, " R8 addr"}, 64'(exc_addr), ev ? 64'(m_addr) : 64'd0);
        end
    end

    task automatic do_req(string tag, bit [3:0] hits, bit [31:0] c0, bit [31:0] c1,
                          bit [31:0] c2, bit [31:0] c3, bit [1:0] lvl, bit sec, bit exp_take);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        cur_tag   = tag;
        slot_hit  = hits;
        slot_ctrl = {c3, c2, c1, c0};
        cur_level = lvl;
        secure    = sec;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        @(negedge clk);
        chk({tag, " take"}, 64'(exc_valid), 64'(exp_take));
        chk({tag, " resume"}, 64'(resume_valid), 64'(!exp_take));
        last_syn  = exc_syndrome;
        last_fsr  = exc_fsr;
        last_addr = exc_addr;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        bit [31:0] ok_all;
        ok_all = mk(3, 1, 0, 0, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R10 reset ready", 64'(req_ready), 64'd1);
        chk("R10 reset exc", 64'(exc_valid), 64'd0);
        chk("R10 reset resume", 64'(resume_valid), 64'd0);

        // R1 global gates
        dbg_ctrl = 32'h0000_7fff;
        do_req("R1 enable bit clear", 4'b0001, ok_all, 0, 0, 0, 2'd1, 0, 0);
        dbg_ctrl = 32'hffff_ffff; dbg_allowed = 0;
        do_req("R1 not allowed", 4'b0001, ok_all, 0, 0, 0, 2'd1, 0, 0);
        dbg_ctrl = 32'h0000_8000; dbg_allowed = 1;
        do_req("R1 both open", 4'b0001, ok_all, 0, 0, 0, 2'd1, 0, 1);

        // R2/R6 raw hit needed
        do_req("R6 no raw hit", 4'b0000, ok_all, ok_all, ok_all, ok_all, 2'd1, 0, 0);
        do_req("R2 hit on slot3 only", 4'b1000, 0, 0, 0, ok_all, 2'd0, 0, 1);

        // R3 security filter
        do_req("R3 ssc2 nonsecure", 4'b0001, mk(3, 1, 2, 0, 0), 0, 0, 0, 2'd1, 0, 0);
        do_req("R3 ssc2 secure", 4'b0001, mk(3, 1, 2, 0, 0), 0, 0, 0, 2'd1, 1, 1);
        do_req("R3 ssc1 secure", 4'b0001, mk(3, 1, 1, 0, 0), 0, 0, 0, 2'd1, 1, 0);
        do_req("R3 ssc3 nonsecure", 4'b0001, mk(3, 1, 3, 0, 0), 0, 0, 0, 2'd1, 0, 1);

        // R4 privilege filter
        do_req("R4 level0 pac1", 4'b0001, mk(1, 1, 0, 0, 0), 0, 0, 0, 2'd0, 0, 0);
        do_req("R4 level0 pac2", 4'b0001, mk(2, 0, 0, 0, 0), 0, 0, 0, 2'd0, 0, 1);
        do_req("R4 level1 pac2", 4'b0001, mk(2, 1, 0, 0, 0), 0, 0, 0, 2'd1, 0, 0);
        do_req("R4 level2 no hmc", 4'b0001, mk(3, 0, 0, 0, 0), 0, 0, 0, 2'd2, 0, 0);
        do_req("R4 level3 hmc only", 4'b0001, mk(0, 1, 0, 0, 0), 0, 0, 0, 2'd3, 0, 1);

        // R5 linked breakpoint
        link_pass = 12'hfdf;
        do_req("R5 link5 fails", 4'b0001, mk(3, 1, 0, 5, 1), 0, 0, 0, 2'd1, 0, 0);
        link_pass = 12'h020;
        do_req("R5 link5 passes", 4'b0001, mk(3, 1, 0, 5, 1), 0, 0, 0, 2'd1, 0, 1);
        link_pass = '1;
        do_req("R5 link13 out of range", 4'b0001, mk(3, 1, 0, 13, 1), 0, 0, 0, 2'd1, 0, 0);

        // R6 mixed slots
        do_req("R6 slot0 fails slot2 passes", 4'b0101, mk(3, 1, 0, 14, 1), 0, ok_all, 0, 2'd1, 0, 1);
        do_req("R6 passing slot has no hit", 4'b1001, mk(0, 0, 0, 0, 0), ok_all, 0,
               mk(3, 1, 2, 0, 0), 2'd1, 0, 0);

        // R7 / R8 report fields
        target_level = 2'd1; is_write = 1; long_desc = 1; hit_addr = 32'hdead_beef;
        do_req("R7 same level write", 4'b0010, 0, ok_all, 0, 0, 2'd1, 0, 1);
        chk("R7 syndrome same-level write", 64'(last_syn), 64'h0000_0000_d600_0062);
        chk("R8 fsr long", 64'(last_fsr), 64'h222);
        chk("R8 address", 64'(last_addr), 64'h0000_0000_dead_beef);
        target_level = 2'd2; is_write = 0; long_desc = 0; hit_addr = 32'h0000_1234;
        do_req("R7 lower level read", 4'b0010, 0, ok_all, 0, 0, 2'd1, 0, 1);
        chk("R7 syndrome lower-level read", 64'(last_syn), 64'h0000_0000_d200_0022);
        chk("R8 fsr short", 64'(last_fsr), 64'h002);

        // R9 request held through the busy window
        @(negedge clk);
        cur_tag = "R9 held request";
        slot_hit = 4'b0001; slot_ctrl = {96'd0, ok_all}; cur_level = 2'd1; secure = 0;
        req_valid = 1;
        @(negedge clk);
        chk("R9 busy after accept", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk("R9 busy in result cycle", 64'(req_ready), 64'd0);
        chk("R9 result one cycle later", 64'(exc_valid), 64'd1);
        @(negedge clk);
        chk("R9 ready again", 64'(req_ready), 64'd1);
        chk("R9 pulse ended", 64'(exc_valid), 64'd0);
        dbg_allowed = 0;
        @(negedge clk);
        req_valid = 0;
        chk("R9 second accept busy", 64'(req_ready), 64'd0);
        @(negedge clk);
        chk("R9 second result resume", 64'(resume_valid), 64'd1);
        dbg_allowed = 1;

        // Random requests against the model
        cur_tag = "R6 random";
        for (int i = 0; i < 400; i++) begin
            int gap;
            gap = int'($urandom_range(0, 2));
            repeat (gap) @(negedge clk);
            @(negedge clk);
            while (!req_ready) @(negedge clk);
            slot_hit     = NS'($urandom);
            slot_ctrl    = {$urandom, $urandom, $urandom, $urandom};
            cur_level    = 2'($urandom);
            target_level = 2'($urandom);
            secure       = 1'($urandom);
            dbg_ctrl     = $urandom | (($urandom_range(0, 3) != 0) ? 32'h8000 : 32'h0);
            dbg_allowed  = ($urandom_range(0, 7) != 0);
            is_write     = 1'($urandom);
            long_desc    = 1'($urandom);
            hit_addr     = $urandom;
            link_pass    = NB'($urandom);
            req_valid    = 1;
            @(negedge clk);
            req_valid    = 0;
        end
        repeat (4) @(negedge clk);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule